// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the 16x oversampling strobe for a 16550-style serial port from one fixed 20 MHz reference clock. The reference first passes through a prescaler. The prescaler's division factor is picked from a small coded set. Its output enable then feeds a phase accumulator that passes on X out of every Y enables. A 16-bit integer divisor then thins that stream into the final 16x tick. The resulting rate is `ref / prescale * X / Y / divisor` ticks per second, which equals sixteen times the baud rate.

Software programs the block through a write-only word-addressed register port. The divisor bytes share their addresses with the data path of a full UART. For that reason they accept writes only while an access bit in the line-control word is set. Any write that changes the rate restarts all three counting stages from zero. The first tick after a reconfiguration is therefore fully deterministic. When X is not below Y, the accumulator stage is disabled, no ticks are produced, and an error output is raised.

Top module: `uart_frac_baud_gen`

## Requirements
- R1: After reset the prescaler code is 4 (divide by 10), X/Y is 0/1, the divisor is 1 and the access bit is clear. In this state `tick_x16` and `frac_en` stay low and `rate_err` is low.
- R2: The prescaler code is written to bits 2:0 of address 10. Codes 0 to 7 divide the reference by 1, 2, 4, 8, 10, 12, 16 and 20.
- R3: Address 11 holds X in bits 31:16 and Y in bits 15:0. When X < Y, `frac_en` pulses at X/Y times the prescaled enable rate.
- R4: The divisor is {address 1 byte, address 0 byte}, taken from bits 7:0 of each write. `tick_x16` pulses once every `divisor` pulses of `frac_en`, and a divisor of 0 acts as 1.
- R5: Bit 7 of a write to address 3 sets or clears the access bit. Writes to addresses 0 and 1 while the access bit is clear change nothing.
- R6: While X >= Y, `rate_err` is high and neither `frac_en` nor `tick_x16` pulses.
- R7: An accepted write to address 0, 1, 10 or 11 clears all stage counters and both strobes. With divide-by-20, X/Y = 1/2 and divisor 1, `frac_en` first rises 40 cycles after the write edge and `tick_x16` rises 41 cycles after it.
- R8: Each `tick_x16` pulse comes one cycle after a `frac_en` pulse.
- R9: With code 4, Y = 65000, X = 59904 and divisor 1, the tick rate is exactly 1,843,200 per second, which is 16 times 115200 baud.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| frac_en | output | 1 | Enable pulse leaving the X/Y stage |
| tick_x16 | output | 1 | 16x oversampling tick |
| rate_err | output | 1 | High while X >= Y |

## Verification
Tick rates are counted over long windows for every prescaler code with a 1/2 fraction; each code gives a distinct count, so a swapped table entry shows up. Separate windows with a 3/4 fraction, with divisors of 5, 258 and 0, and with the 115200-baud setting separate errors in the accumulator compare, the byte order of the divisor and the zero-divisor rule. Stepping cycle by cycle after a mid-period rewrite pins down the restart latency. Runs with X equal to and above Y, and a divisor write made while the access bit is clear, confirm that those inputs have no effect on the tick.

// File: rtl/uart_frac_baud_gen.sv
module uart_frac_baud_gen #(
  parameter int          AW        = 4,
  parameter int          FW        = 16,
  parameter int          BW        = 8,
  parameter int          PW        = 3,
  parameter logic [2:0]  PSC_RST   = 3'd4,
  parameter logic [31:0] XY_RST    = 32'h0000_0001,
  parameter int          A_DLO     = 0,
  parameter int          A_DHI     = 1,
  parameter int          A_LINE    = 3,
  parameter int          ACC_BIT   = 7,
  parameter int          A_PSC     = 10,
  parameter int          A_XY      = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [2*FW-1:0] wr_data,
  output logic            frac_en,
  output logic            tick_x16,
  output logic            rate_err
);
  localparam int DW = 2 * FW;
  localparam int CW = 5;
  localparam int VW = 2 * BW;

  function automatic logic [CW-1:0] psc_div(input logic [PW-1:0] c);
    case (c)
      3'd0: return 5'd1;
      3'd1: return 5'd2;
      3'd2: return 5'd4;
      3'd3: return 5'd8;
      3'd4: return 5'd10;
      3'd5: return 5'd12;
      3'd6: return 5'd16;
      default: return 5'd20;
    endcase
  endfunction

  logic          dl_acc;
  logic [PW-1:0] psc_code;
  logic [DW-1:0] xy;
  logic [BW-1:0] dl_lo, dl_hi;
  logic [CW-1:0] pc;
  logic [FW-1:0] acc;
  logic [VW-1:0] dc;
  logic          frac_q, tick_q;

  wire [FW-1:0] x_v = xy[DW-1:FW];
  wire [FW-1:0] y_v = xy[FW-1:0];
  wire [VW-1:0] dv  = {dl_hi, dl_lo};
  wire [VW-1:0] dv_last = (dv == '0) ? '0 : dv - 1'b1;
  wire [CW-1:0] div_v = psc_div(psc_code);

  wire a_lo   = wr_addr == AW'(A_DLO);
  wire a_hi   = wr_addr == AW'(A_DHI);
  wire a_line = wr_addr == AW'(A_LINE);
  wire a_psc  = wr_addr == AW'(A_PSC);
  wire a_xy   = wr_addr == AW'(A_XY);
  wire rate_wr = wr_en && (a_psc || a_xy || (dl_acc && (a_lo || a_hi)));

  assign rate_err = x_v >= y_v;

  wire          pre_en = pc == div_v - 1'b1;
  wire [FW:0]   sum    = {1'b0, acc} + {1'b0, x_v};
  wire [FW:0]   diff   = sum - {1'b0, y_v};
  wire          hit    = pre_en && !rate_err && (sum >= {1'b0, y_v});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_acc   <= 1'b0;
      psc_code <= PSC_RST;
      xy       <= XY_RST;
      dl_lo    <= BW'(1);
      dl_hi    <= '0;
    end else if (wr_en) begin
      if (a_line) dl_acc <= wr_data[ACC_BIT];
      if (a_psc) psc_code <= wr_data[PW-1:0];
      if (a_xy) xy <= wr_data;
      if (a_lo && dl_acc) dl_lo <= wr_data[BW-1:0];
      if (a_hi && dl_acc) dl_hi <= wr_data[BW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rate_wr) begin
      pc     <= '0;
      acc    <= '0;
      dc     <= '0;
      frac_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      pc <= pre_en ? '0 : pc + 1'b1;
      if (pre_en && !rate_err) acc <= hit ? diff[FW-1:0] : sum[FW-1:0];
      frac_q <= hit;
      tick_q <= frac_q && (dc == dv_last);
      if (frac_q) dc <= (dc == dv_last) ? '0 : dc + 1'b1;
    end
  end

  assign frac_en  = frac_q;
  assign tick_x16 = tick_q;

  AST_PSC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pc < div_v); // R2
  AST_ACC_BELOW_Y: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_err |-> acc < y_v); // R3
  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dc <= dv_last); // R4
  AST_LOCKED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a_lo && !dl_acc) |=> $stable(dl_lo)); // R5
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    rate_err |-> (!frac_en && !tick_x16)); // R6
  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr |=> (!frac_en && !tick_x16 && pc == '0)); // R7
  AST_TICK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_x16 |-> $past(frac_en)); // R8
endmodule

// File: tb/uart_frac_baud_gen_bench.sv
module uart_frac_baud_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        frac_en, tick_x16, rate_err;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_frac_baud_gen u_uart_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frac_en(frac_en), .tick_x16(tick_x16),
    .rate_err(rate_err));

  task automatic chk(input string req, input int act, input int exp, input int tol);
    total++;
    if (act < exp - tol || act > exp + tol) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int code, input int x, input int y, input int dv);
    wr(4'd10, 32'(code));
    wr(4'd11, {x[15:0], y[15:0]});
    wr(4'd3, 32'h80);
    wr(4'd0, 32'(dv & 8'hff));
    wr(4'd1, 32'((dv >> 8) & 8'hff));
    wr(4'd3, 32'h00);
  endtask

  task automatic count(input int w, output int n);
    n = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (tick_x16) n++;
    end
  endtask

  task automatic t_reset;
    int n;
    chk("R1 tick at reset", int'(tick_x16), 0, 0);
    chk("R1 err at reset", int'(rate_err), 0, 0);
    count(300, n);
    chk("R1 no ticks with X=0", n, 0, 0);
    wr(4'd11, 32'h0001_0002);
    count(4000, n);
    chk("R1 default divide by 10, divisor 1", n, 200, 2);
  endtask

  task automatic t_prescale;
    int divs[8] = '{1, 2, 4, 8, 10, 12, 16, 20};
    int n;
    for (int c = 0; c < 8; c++) begin
      cfg(c, 1, 2, 1);
      count(4000, n);
      chk($sformatf("R2 code %0d", c), n, 4000 / (2 * divs[c]), 2);
    end
  endtask

  task automatic t_fraction;
    int n;
    cfg(0, 3, 4, 1);
    count(4000, n);
    chk("R3 X/Y=3/4", n, 3000, 2);
  endtask

  task automatic t_divisor;
    int n;
    cfg(0, 1, 2, 5);
    count(4000, n);
    chk("R4 divisor 5", n, 400, 2);
    cfg(0, 1, 2, 258);
    count(20000, n);
    chk("R4 divisor 258 byte order", n, 38, 2);
    cfg(0, 1, 2, 0);
    count(4000, n);
    chk("R4 divisor 0 as 1", n, 2000, 2);
  endtask

  task automatic t_access;
    int n;
    cfg(0, 1, 2, 5);
    wr(4'd0, 32'h01);
    wr(4'd1, 32'h01);
    wr(4'd11, 32'h0001_0002);
    count(4000, n);
    chk("R5 locked divisor bytes unchanged", n, 400, 2);
  endtask

  task automatic t_error;
    int n;
    cfg(0, 2, 2, 1);
    chk("R6 err X=Y", int'(rate_err), 1, 0);
    count(2000, n);
    chk("R6 no ticks X=Y", n, 0, 0);
    cfg(0, 9, 4, 1);
    chk("R6 err X>Y", int'(rate_err), 1, 0);
    count(2000, n);
    chk("R6 no ticks X>Y", n, 0, 0);
    wr(4'd11, 32'h0001_0002);
    chk("R6 err clears", int'(rate_err), 0, 0);
  endtask

  task automatic t_restart;
    int n, first_f, first_t;
    cfg(7, 1, 2, 1);
    count(57, n);
    wr(4'd11, 32'h0001_0002);
    first_f = 0; first_t = 0;
    for (int k = 1; k <= 45; k++) begin
      @(negedge clk);
      if (frac_en && first_f == 0) first_f = k;
      if (tick_x16 && first_t == 0) first_t = k;
    end
    chk("R7 first frac_en after rewrite", first_f, 40, 0);
    chk("R7 first tick after rewrite", first_t, 41, 0);
    chk("R8 tick one cycle after frac_en", first_t - first_f, 1, 0);
  endtask

  task automatic t_baud;
    int n;
    cfg(4, 59904, 65000, 1);
    count(50000, n);
    chk("R9 16x115200 tick count", n, 4608, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_fraction();
    t_divisor();
    t_access();
    t_error();
    t_restart();
    t_baud();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule